// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the digital control core of a secondary-side synchronous rectifier controller for push-pull and full-bridge power converters. A three-level synchronization waveform arrives from the primary side through a small transformer. Two analog comparators turn it into a positive-pulse flag and a negative-pulse flag. The block decodes these flags into two registered gate enables, `gateE` and `gateF`, one for each rectifier switch. A positive pulse turns E off. A negative pulse turns F off. The zero band between pulses turns both switches on, which is the free-wheeling interval.

The block also protects the switches. It checks that pulse polarities alternate. It watches a reverse-current flag for each switch, but only once a blanking interval after that switch's turn-on has passed. It runs a restartable timeout, so that a lost sync waveform drops both gates. An undervoltage flag, already debounced outside the block, forces both gates off.

All four comparator flags pass through two-flop synchronizers. A gate output therefore responds on the third rising clock edge after a raw flag changes. The undervoltage flag is used without synchronization and acts on the next edge.

Top module: `sr_drive_seq`

## Requirements
- R1: While the synchronized sync level is positive (`syncPos`=1, `syncNeg`=0) and the block is armed with no fault, `gateE` is 0 and `gateF` is 1.
- R2: While the synchronized sync level is negative (`syncNeg`=1, `syncPos`=0) and no other condition blocks the gates, `gateF` is 0 and `gateE` is 1.
- R3: In the zero band (both flags 0), both gates are 1. This holds only once a negative pulse has been seen since reset; until then both gates stay 0 whatever the sync level.
- R4: A positive pulse whose previous pulse was also positive forces both gates to 0. They stay 0 through the zero band until a negative pulse arrives; the normal R2 and R3 behaviour then resumes.
- R5: A negative pulse whose previous pulse was also negative forces both gates to 0 until a positive pulse arrives. A single-flag weak pulse is treated as a pulse of that polarity, so it falls under R4 or R5.
- R6: A reverse-current flag has no effect during the first BLANK_CYC cycles after its gate rises. Once that window has passed, the asserted flag drives that gate to 0, and the gate stays 0 until the next positive or negative pulse begins, even if the flag clears first.
- R7: Each change of sync level restarts the timeout and holds the count at zero for RSTPULSE_CYC cycles. If `timeoutLoad` further cycles pass with no level change, both gates go to 0 until the next level change.
- R8: A `timeoutLoad` of 0 disables the timeout, so the gates hold their sync-decoded values for any length of time.
- R9: `uvFlag`=1 forces both gates to 0 on the next clock edge. Clearing it restores the sync-decoded values.
- R10: Synchronous reset drives both gates to 0 and clears the armed state, so a negative pulse is needed again after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| syncPos | input | 1 | Raw positive sync comparator flag |
| syncNeg | input | 1 | Raw negative sync comparator flag |
| revCurE | input | 1 | Raw reverse-current flag for switch E |
| revCurF | input | 1 | Raw reverse-current flag for switch F |
| uvFlag | input | 1 | Debounced undervoltage flag, 1 = supply low |
| timeoutLoad | input | TIMER_W | Timeout length in cycles, 0 = timeout off |
| gateE | output | 1 | Registered gate enable for switch E |
| gateF | output | 1 | Registered gate enable for switch F |

## Verification
The bench first applies a clean alternating positive, zero, negative, zero cycle several times over. This shows that each gate drops only on its own polarity and that both gates rise in the zero band. Separate sequences then follow. Pulses arrive before the first negative one, to separate arming from decoding. Repeated positive pulses and repeated negative pulses are applied, to show that only the opposite polarity clears the fault. A reverse-current flag is raised at the instant of turn-on and sampled inside and beyond the blanking window, which separates ignoring the flag from latching it. The timeout is run with a load of zero and with a short load, and undervoltage and mid-run reset are applied.

// File: rtl/srdrv_pkg.sv
package srdrv_pkg;
  typedef enum logic [1:0] {
    LEV_ZERO = 2'd0,
    LEV_POS  = 2'd1,
    LEV_NEG  = 2'd2
  } level_e;

  // status from datapath to control
  typedef struct packed {
    logic entPos;
    logic entNeg;
    logic change;
    logic levPos;
    logic levNeg;
    logic expired;
    logic blankDoneE;
    logic blankDoneF;
    logic revE;
    logic revF;
  } dpStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerRestart;
    logic enE;
    logic enF;
  } ctlStrobe_t;
endpackage

// File: rtl/srdrv_gatechan.sv
module srdrv_gatechan #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic gate,
  output logic blankDone
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  logic [BW-1:0] blankCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate     <= 1'b0;
      blankCnt <= '0;
    end else begin
      gate <= en;
      if (!gate) blankCnt <= '0;
      else if (blankCnt != BW'(BLANK_CYC)) blankCnt <= blankCnt + 1'b1;
    end
  end

  assign blankDone = gate && (blankCnt == BW'(BLANK_CYC));
endmodule

// File: rtl/srdrv_datapath.sv
module srdrv_datapath
  import srdrv_pkg::*;
#(
  parameter int TIMER_W      = 8,
  parameter int BLANK_CYC    = 25,
  parameter int RSTPULSE_CYC = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         rawFlags,   // {revF, revE, neg, pos}
  input  logic [TIMER_W-1:0] timeoutLoad,
  input  ctlStrobe_t         ctl,
  output dpStatus_t          stat,
  output logic               gateE,
  output logic               gateF
);
  localparam int NFLAG = 4;
  localparam int PW    = $clog2(RSTPULSE_CYC + 1);

  logic [NFLAG-1:0] syncA, syncB;
  level_e prevLev, curLev;
  logic [TIMER_W-1:0] tCnt;
  logic [PW-1:0] pCnt;
  logic [1:0] chanEn, chanGate, chanDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= rawFlags;
      syncB <= syncA;
    end
  end

  // both flags at once cannot be a valid level; hold the previous one
  always_comb begin
    case (syncB[1:0])
      2'b01:   curLev = LEV_POS;
      2'b10:   curLev = LEV_NEG;
      2'b00:   curLev = LEV_ZERO;
      default: curLev = prevLev;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prevLev <= LEV_ZERO;
    else     prevLev <= curLev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tCnt <= '0;
      pCnt <= '0;
    end else if (ctl.timerRestart) begin
      tCnt <= '0;
      pCnt <= PW'(RSTPULSE_CYC);
    end else if (pCnt != '0) begin
      pCnt <= pCnt - 1'b1;
    end else if (timeoutLoad != '0 && tCnt < timeoutLoad) begin
      tCnt <= tCnt + 1'b1;
    end
  end

  assign chanEn = {ctl.enF, ctl.enE};

  for (genvar i = 0; i < 2; i++) begin : g_chan
    srdrv_gatechan #(.BLANK_CYC(BLANK_CYC)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (chanEn[i]),
      .gate     (chanGate[i]),
      .blankDone(chanDone[i])
    );
  end

  assign gateE = chanGate[0];
  assign gateF = chanGate[1];

  always_comb begin
    stat.change     = (curLev != prevLev);
    stat.entPos     = stat.change && (curLev == LEV_POS);
    stat.entNeg     = stat.change && (curLev == LEV_NEG);
    stat.levPos     = (curLev == LEV_POS);
    stat.levNeg     = (curLev == LEV_NEG);
    stat.expired    = (timeoutLoad != '0) && (pCnt == '0) && (tCnt >= timeoutLoad);
    stat.blankDoneE = chanDone[0];
    stat.blankDoneF = chanDone[1];
    stat.revE       = syncB[2];
    stat.revF       = syncB[3];
  end
endmodule

// File: rtl/srdrv_control.sv
module srdrv_control
  import srdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpStatus_t  stat,
  input  logic       uvFlag,
  output ctlStrobe_t ctl
);
  level_e lastPol, lastPolN;
  logic fault, faultN, armed, armedN;
  logic tripE, tripEN, tripF, tripFN;
  logic blockAll;

  always_comb begin
    lastPolN = lastPol;
    faultN   = fault;
    armedN   = armed;
    tripEN   = tripE | (stat.blankDoneE & stat.revE);
    tripFN   = tripF | (stat.blankDoneF & stat.revF);
    if (stat.entPos) begin
      faultN   = (lastPol == LEV_POS);
      lastPolN = LEV_POS;
      tripEN   = 1'b0;
      tripFN   = 1'b0;
    end
    if (stat.entNeg) begin
      faultN   = (lastPol == LEV_NEG);
      lastPolN = LEV_NEG;
      armedN   = 1'b1;
      tripEN   = 1'b0;
      tripFN   = 1'b0;
    end
    blockAll = ~armedN | faultN | (stat.expired & ~stat.change) | uvFlag;
    ctl.timerRestart = stat.change;
    ctl.enE = ~blockAll & ~stat.levPos & ~tripEN;
    ctl.enF = ~blockAll & ~stat.levNeg & ~tripFN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastPol <= LEV_ZERO;
      fault   <= 1'b0;
      armed   <= 1'b0;
      tripE   <= 1'b0;
      tripF   <= 1'b0;
    end else begin
      lastPol <= lastPolN;
      fault   <= faultN;
      armed   <= armedN;
      tripE   <= tripEN;
      tripF   <= tripFN;
    end
  end
endmodule

// File: rtl/sr_drive_seq.sv
module sr_drive_seq
  import srdrv_pkg::*;
#(
  parameter int TIMER_W      = 8,
  parameter int BLANK_CYC    = 25,
  parameter int RSTPULSE_CYC = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               syncPos,
  input  logic               syncNeg,
  input  logic               revCurE,
  input  logic               revCurF,
  input  logic               uvFlag,
  input  logic [TIMER_W-1:0] timeoutLoad,
  output logic               gateE,
  output logic               gateF
);
  dpStatus_t  stat;
  ctlStrobe_t ctl;

  srdrv_datapath #(
    .TIMER_W(TIMER_W), .BLANK_CYC(BLANK_CYC), .RSTPULSE_CYC(RSTPULSE_CYC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .rawFlags   ({revCurF, revCurE, syncNeg, syncPos}),
    .timeoutLoad(timeoutLoad),
    .ctl        (ctl),
    .stat       (stat),
    .gateE      (gateE),
    .gateF      (gateF)
  );

  srdrv_control u_ctl (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat),
    .uvFlag(uvFlag),
    .ctl   (ctl)
  );
endmodule

// File: rtl/sr_drive_seq_chk.sv
module sr_drive_seq_chk
  import srdrv_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       uvFlag,
  input logic       gateE,
  input logic       gateF,
  input dpStatus_t  stat,
  input logic [1:0] lastPol
);
  AST_POS_DROPS_E: assert property (@(posedge clk) disable iff (rst)
    stat.levPos |=> !gateE) else $error("positive level kept gateE"); // R1

  AST_NEG_DROPS_F: assert property (@(posedge clk) disable iff (rst)
    stat.levNeg |=> !gateF) else $error("negative level kept gateF"); // R2

  AST_DOUBLE_POS_OFF: assert property (@(posedge clk) disable iff (rst)
    (stat.entPos && lastPol == 2'(LEV_POS)) |=> (!gateE && !gateF))
    else $error("repeated positive pulse left a gate on"); // R4

  AST_DOUBLE_NEG_OFF: assert property (@(posedge clk) disable iff (rst)
    (stat.entNeg && lastPol == 2'(LEV_NEG)) |=> (!gateE && !gateF))
    else $error("repeated negative pulse left a gate on"); // R5

  AST_TIMEOUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (stat.expired && !stat.change) |=> (!gateE && !gateF))
    else $error("expired timeout left a gate on"); // R7

  AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
    uvFlag |=> (!gateE && !gateF)) else $error("undervoltage left a gate on"); // R9
endmodule

bind sr_drive_seq sr_drive_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .uvFlag (uvFlag),
  .gateE  (gateE),
  .gateF  (gateF),
  .stat   (stat),
  .lastPol(u_ctl.lastPol)
);

// File: tb/sim_sr_drive_seq.sv
module sim_sr_drive_seq;
  localparam int TW = 8;
  localparam int BLANK = 16;
  localparam int RSTP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic syncPos = 1'b0, syncNeg = 1'b0, revCurE = 1'b0, revCurF = 1'b0, uvFlag = 1'b0;
  logic [TW-1:0] timeoutLoad = '0;
  logic gateE, gateF;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sr_drive_seq #(.TIMER_W(TW), .BLANK_CYC(BLANK), .RSTPULSE_CYC(RSTP)) u0 (
    .clk(clk), .rst(rst), .syncPos(syncPos), .syncNeg(syncNeg),
    .revCurE(revCurE), .revCurF(revCurF), .uvFlag(uvFlag),
    .timeoutLoad(timeoutLoad), .gateE(gateE), .gateF(gateF)
  );

  // expected value is {gateE, gateF}
  task automatic chk(input string req, input logic [1:0] expv);
    nChecks++;
    if ({gateE, gateF} !== expv) begin
      nFail++;
      $display("FAIL %s: {gateE,gateF} actual=%b expected=%b at %0t", req, {gateE, gateF}, expv, $time);
    end
  endtask

  task automatic level(input logic p, input logic n, input int waitCyc);
    @(negedge clk);
    syncPos = p;
    syncNeg = n;
    repeat (waitCyc) @(negedge clk);
  endtask

  task automatic idle(input int waitCyc);
    repeat (waitCyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", 2'b00);
    rst = 1'b0;
    level(0, 0, 6);  chk("R3 zero before arming", 2'b00);
    level(1, 0, 6);  chk("R3 positive before arming", 2'b00);
    level(0, 1, 6);  chk("R2 first negative arms", 2'b10);
    level(0, 0, 6);  chk("R3 zero band after arming", 2'b11);

    for (int i = 0; i < 4; i++) begin
      level(1, 0, 6); chk("R1 sweep positive", 2'b01);
      level(0, 0, 6); chk("R3 sweep zero", 2'b11);
      level(0, 1, 6); chk("R2 sweep negative", 2'b10);
      level(0, 0, 6); chk("R3 sweep zero", 2'b11);
    end

    // repeated positive
    level(1, 0, 6); chk("R4 first positive", 2'b01);
    level(0, 0, 6); chk("R4 zero", 2'b11);
    level(1, 0, 6); chk("R4 second positive", 2'b00);
    level(0, 0, 6); chk("R4 zero after fault", 2'b00);
    level(0, 1, 6); chk("R4 negative clears", 2'b10);
    level(0, 0, 6); chk("R4 zero after clear", 2'b11);

    // repeated negative
    level(0, 1, 6); chk("R5 second negative", 2'b00);
    level(0, 0, 6); chk("R5 zero after fault", 2'b00);
    level(1, 0, 6); chk("R5 positive clears", 2'b01);

    // reverse current on E at turn-on
    @(negedge clk);
    syncPos = 1'b0;
    revCurE = 1'b1;
    idle(8);  chk("R6 flag ignored in blanking", 2'b11);
    idle(22); chk("R6 flag trips after blanking", 2'b01);
    revCurE = 1'b0;
    idle(6);  chk("R6 trip latched", 2'b01);
    level(0, 1, 6); chk("R6 pulse re-arms", 2'b10);
    level(0, 0, 6); chk("R6 zero after re-arm", 2'b11);

    // timeout
    @(negedge clk);
    timeoutLoad = 8'd40;
    syncPos = 1'b1;
    idle(25); chk("R7 before expiry", 2'b01);
    idle(45); chk("R7 after expiry", 2'b00);
    level(0, 0, 6); chk("R7 level change restores", 2'b11);
    timeoutLoad = '0;
    level(0, 1, 6);   chk("R8 negative", 2'b10);
    level(0, 0, 200); chk("R8 long zero with timeout off", 2'b11);

    // undervoltage
    @(negedge clk);
    uvFlag = 1'b1;
    idle(3); chk("R9 undervoltage", 2'b00);
    uvFlag = 1'b0;
    idle(3); chk("R9 undervoltage released", 2'b11);

    // reset mid-run
    rst = 1'b1;
    idle(3); chk("R10 reset mid-run", 2'b00);
    rst = 1'b0;
    idle(10); chk("R10 disarmed after reset", 2'b00);
    level(0, 1, 6); chk("R10 re-armed by negative", 2'b10);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule